// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

An eight-input priority interrupt controller in the classic cascadable style. A host reaches it through an 8-bit register port with a single address bit. Address 0 takes command writes and returns status reads. Address 1 takes the mask and the trailing words of the start-up sequence.

Requests are latched on rising input edges. The host services them by polling rather than by a vectored acknowledge. A poll command is followed by one status read. That read returns the winning level and moves it from pending to in service. The host then retires the level with an end-of-interrupt command.

The priority order is a rotation. An explicit command names the level that ranks last, and the order continues upward from the level after it. The start-up sequence stores a vector base and a cascade word, and both are exposed as outputs. The single output line tells the host that a poll would find work.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is 0xFF and the pending and in-service registers are 0x00. `int_out` is low, the priority order runs from level 0 (highest) to level 7 (lowest), and status reads at address 0 return the pending register.
- R2: A write to address 0 with bit 4 set starts initialization. In that word, bit 1 set means there is no cascade word and bit 0 set means a mode word follows. The write clears the pending and in-service registers, restores the default priority order, selects the pending register for status reads and leaves the mask unchanged. The following address-1 writes are taken in order as the vector base (`vec_base`), the cascade word (`casc_word`, skipped when bit 1 was set) and the mode word (skipped when bit 0 was clear).
- R3: Outside the initialization sequence, a write to address 1 loads the mask (1 = masked), and a read of address 1 returns the mask.
- R4: A rising edge on `irq_in[i]` sets pending bit i. A line held high sets its bit only once.
- R5: `int_out` is high exactly when some unmasked pending level ranks above every level in service.
- R6: A command whose bits 7:5 are 110 makes the level in bits 2:0 the lowest priority. The order then runs from that level plus 1, upward with wrap, and ends at that level (0xC2 gives 3,4,5,6,7,0,1,2).
- R7: A command with bit 4 clear and bits 3 and 2 set is a poll. The next address-0 read returns 0x80 ORed with the winning level, sets that in-service bit and clears that pending bit. Only that one read is affected.
- R8: A poll read that finds no qualifying request returns 0x07 and changes no in-service bit.
- R9: A command with bit 4 clear, bit 3 set and bits 1:0 equal to 11 selects the in-service register for later status reads. Bits 1:0 equal to 10 selects the pending register.
- R10: A command with bits 7:5 equal to 011 clears only the in-service bit of the level in bits 2:0.
- R11: A command with bits 7:5 equal to 001 clears the in-service bit of the highest-priority level in service.
- R12: A masked pending bit stays pending but does not raise `int_out` and is not returned by a poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register address bit |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (valid in the cycle of `reg_rd`) |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt output to the host |
| vec_base | output | 8 | Stored vector base word |
| casc_word | output | 8 | Stored cascade word |

## Verification
The assertions assume that the host never asserts `reg_wr` and `reg_rd` in the same cycle. Under that assumption a poll read and a command write cannot both change the in-service register in one cycle. The bench drives each access as a single-cycle strobe separated from the next by an idle cycle. It changes request lines only on falling clock edges, one access at a time.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int LINES  = 8;
    localparam int LVL_W  = $clog2(LINES);
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        STEP_RUN,
        STEP_VEC,
        STEP_CASC,
        STEP_MODE
    } init_step_e;

    typedef struct packed {
        init_step_e          step;
        logic                want_mode;
        logic                solo;
        logic [LINES-1:0]    irr;
        logic [LINES-1:0]    isr;
        logic [LINES-1:0]    imr;
        logic [LINES-1:0]    prev;
        logic [LVL_W-1:0]    lowest;
        logic                sel_isr;
        logic                poll_pend;
        logic [DATA_W-1:0]   vec_base;
        logic [DATA_W-1:0]   casc_word;
    } pic_state_t;
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] top_lvl,
    output logic         found,
    output logic [W-1:0] rank,
    output logic [W-1:0] lvl
);
    // Walk from lowest rank to highest so the highest-ranked hit is kept.
    always_comb begin
        found = 1'b0;
        rank  = '0;
        lvl   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            logic [W-1:0] idx;
            idx = W'(top_lvl + W'(i));
            if (vec[idx]) begin
                found = 1'b1;
                rank  = W'(i);
                lvl   = idx;
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [LINES-1:0]  irq_in,
    output logic              int_out,
    output logic [DATA_W-1:0] vec_base,
    output logic [DATA_W-1:0] casc_word
);
    pic_state_t st_q, st_d;

    logic [LVL_W-1:0] top_lvl;
    logic             rq_found, is_found;
    logic [LVL_W-1:0] rq_rank, rq_lvl, is_rank, is_lvl;
    logic             req_ok;
    logic             in_run;
    logic             poll_rd;
    logic [LINES-1:0] rise;

    assign top_lvl = LVL_W'(st_q.lowest + 1'b1);
    assign in_run  = (st_q.step == STEP_RUN);

    pic_prio_pick #(.N(LINES)) u_pick_req (
        .vec     (st_q.irr & ~st_q.imr),
        .top_lvl (top_lvl),
        .found   (rq_found),
        .rank    (rq_rank),
        .lvl     (rq_lvl)
    );

    pic_prio_pick #(.N(LINES)) u_pick_isr (
        .vec     (st_q.isr),
        .top_lvl (top_lvl),
        .found   (is_found),
        .rank    (is_rank),
        .lvl     (is_lvl)
    );

    assign req_ok  = rq_found && (!is_found || (rq_rank < is_rank));
    assign int_out = req_ok;
    assign poll_rd = reg_rd && !reg_addr && st_q.poll_pend;
    assign rise    = irq_in & ~st_q.prev;

    assign vec_base  = st_q.vec_base;
    assign casc_word = st_q.casc_word;

    always_comb begin
        if (reg_addr)
            reg_rdata = st_q.imr;
        else if (st_q.poll_pend)
            reg_rdata = {req_ok, {(DATA_W-1-LVL_W){1'b0}},
                         (req_ok ? rq_lvl : {LVL_W{1'b1}})};
        else if (st_q.sel_isr)
            reg_rdata = st_q.isr;
        else
            reg_rdata = st_q.irr;
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;

        if (poll_rd) begin
            st_d.poll_pend = 1'b0;
            if (req_ok) begin
                st_d.isr[rq_lvl] = 1'b1;
                st_d.irr[rq_lvl] = 1'b0;
            end
        end

        if (reg_wr) begin
            if (!reg_addr) begin
                if (reg_wdata[4]) begin
                    st_d.step      = STEP_VEC;
                    st_d.want_mode = reg_wdata[0];
                    st_d.solo      = reg_wdata[1];
                    st_d.irr       = '0;
                    st_d.isr       = '0;
                    st_d.lowest    = LVL_W'(LINES - 1);
                    st_d.sel_isr   = 1'b0;
                    st_d.poll_pend = 1'b0;
                end else if (reg_wdata[3]) begin
                    if (reg_wdata[2])
                        st_d.poll_pend = 1'b1;
                    if (reg_wdata[1])
                        st_d.sel_isr = reg_wdata[0];
                end else begin
                    case (reg_wdata[7:5])
                        3'b001: if (is_found) st_d.isr[is_lvl] = 1'b0;
                        3'b011: st_d.isr[reg_wdata[LVL_W-1:0]] = 1'b0;
                        3'b110: st_d.lowest = reg_wdata[LVL_W-1:0];
                        default: ;
                    endcase
                end
            end else if (in_run) begin
                st_d.imr = reg_wdata;
            end else begin
                case (st_q.step)
                    STEP_VEC: begin
                        st_d.vec_base = reg_wdata;
                        if (!st_q.solo)
                            st_d.step = STEP_CASC;
                        else
                            st_d.step = st_q.want_mode ? STEP_MODE : STEP_RUN;
                    end
                    STEP_CASC: begin
                        st_d.casc_word = reg_wdata;
                        st_d.step = st_q.want_mode ? STEP_MODE : STEP_RUN;
                    end
                    default: st_d.step = STEP_RUN;
                endcase
            end
        end

        st_d.irr = st_d.irr | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.step      <= STEP_RUN;
            st_q.imr       <= '1;
            st_q.lowest    <= LVL_W'(LINES - 1);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import prio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              int_out,
    input logic              poll_rd,
    input logic              in_run,
    input logic [LINES-1:0]  irr,
    input logic [LINES-1:0]  isr,
    input logic [LINES-1:0]  imr
);
    // R5
    int_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != '0));

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && in_run) |=> (imr == $past(reg_wdata)));

    // R7
    poll_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && int_out && !reg_wr) |=>
            ($countones(isr) == $past($countones(isr)) + 1));

    // R8
    poll_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && !int_out && !reg_wr) |=> $stable(isr));

    // R10
    eoi_specific_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && reg_wdata[7:3] == 5'b01100 && !poll_rd) |=>
            !isr[$past(reg_wdata[LVL_W-1:0])]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .int_out   (int_out),
    .poll_rd   (poll_rd),
    .in_run    (in_run),
    .irr       (st_q.irr),
    .isr       (st_q.isr),
    .imr       (st_q.imr)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_out;
    logic [7:0] vec_base, casc_word;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .int_out(int_out), .vec_base(vec_base),
        .casc_word(casc_word)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_irr, m_isr, m_imr, m_prev, m_vec, m_casc;
    int         m_low, m_step;
    bit         m_sel_isr, m_poll, m_need4, m_single;

    function automatic int rank_of(logic [7:0] v);
        for (int k = 1; k <= 8; k++)
            if (v[(m_low + k) % 8]) return k;
        return 99;
    endfunction

    function automatic int lvl_of(logic [7:0] v);
        for (int k = 1; k <= 8; k++)
            if (v[(m_low + k) % 8]) return (m_low + k) % 8;
        return -1;
    endfunction

    function automatic bit m_int();
        int a;
        a = rank_of(m_irr & ~m_imr);
        return (a != 99) && (a < rank_of(m_isr));
    endfunction

    function automatic logic [7:0] m_read(bit addr);
        if (addr) return m_imr;
        if (m_poll) return m_int() ? (8'h80 | 8'(lvl_of(m_irr & ~m_imr))) : 8'h07;
        return m_sel_isr ? m_isr : m_irr;
    endfunction

    always @(posedge clk) begin : model
        logic [7:0] rise;
        bit         grant;
        int         wl, il;
        if (!rst_n) begin
            m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_prev = 0; m_vec = 0; m_casc = 0;
            m_low = 7; m_step = 0; m_sel_isr = 0; m_poll = 0; m_need4 = 0; m_single = 0;
        end else begin
            rise  = irq_in & ~m_prev;
            m_prev = irq_in;
            grant = m_int();
            wl    = lvl_of(m_irr & ~m_imr);
            il    = lvl_of(m_isr);
            if (reg_rd && !reg_addr && m_poll) begin
                m_poll = 0;
                if (grant) begin m_isr[wl] = 1; m_irr[wl] = 0; end
            end
            if (reg_wr && !reg_addr) begin
                if (reg_wdata[4]) begin
                    m_step = 1; m_need4 = reg_wdata[0]; m_single = reg_wdata[1];
                    m_irr = 0; m_isr = 0; m_low = 7; m_sel_isr = 0; m_poll = 0;
                end else if (reg_wdata[3]) begin
                    if (reg_wdata[2]) m_poll = 1;
                    if (reg_wdata[1]) m_sel_isr = reg_wdata[0];
                end else if (reg_wdata[7:5] == 3'b001) begin
                    if (il >= 0) m_isr[il] = 0;
                end else if (reg_wdata[7:5] == 3'b011) begin
                    m_isr[reg_wdata[2:0]] = 0;
                end else if (reg_wdata[7:5] == 3'b110) begin
                    m_low = int'(reg_wdata[2:0]);
                end
            end else if (reg_wr && reg_addr) begin
                if (m_step == 0) m_imr = reg_wdata;
                else if (m_step == 1) begin
                    m_vec = reg_wdata;
                    m_step = !m_single ? 2 : (m_need4 ? 3 : 0);
                end else if (m_step == 2) begin
                    m_casc = reg_wdata;
                    m_step = m_need4 ? 3 : 0;
                end else m_step = 0;
            end
            m_irr = m_irr | rise;
        end
    end

    // ---------------- checking ----------------
    task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // R5: per-clock comparison of the interrupt line and stored words
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int_out == m_int(), "R5 int_out vs model", 8'(int_out), 8'(m_int()));
            check(vec_base == m_vec && casc_word == m_casc, "R2 stored words vs model",
                  vec_base ^ casc_word, m_vec ^ m_casc);
        end
    end

    task automatic wr(bit a, logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(bit a, logic [7:0] exp, string tag);
        logic [7:0] mexp;
        @(negedge clk); reg_rd = 1; reg_addr = a;
        #1;
        mexp = m_read(a);
        check(reg_rdata == exp, tag, reg_rdata, exp);
        check(reg_rdata == mexp, {tag, " model"}, reg_rdata, mexp);
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic pulse(int line);
        @(negedge clk); irq_in[line] = 1;
        @(negedge clk); irq_in[line] = 0;
    endtask

    task automatic chk_int(bit exp, string tag);
        @(negedge clk); #1;
        check(int_out == exp, tag, 8'(int_out), 8'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk_int(0, "R1 int_out after reset");
        rd(0, 8'h00, "R1 pending after reset");
        rd(1, 8'hFF, "R1 mask after reset");

        // R2 full init: 0x11, vector, cascade, mode
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
        @(negedge clk); #1;
        check(vec_base == 8'h20, "R2 vector base", vec_base, 8'h20);
        check(casc_word == 8'h04, "R2 cascade word", casc_word, 8'h04);
        rd(1, 8'hFF, "R2 mask unchanged by init");
        wr(1, 8'h00);
        rd(1, 8'h00, "R3 mask load");

        // R4 edge latch, default order
        pulse(5); pulse(2);
        rd(0, 8'h24, "R4 pending after edges");
        chk_int(1, "R5 int_out with pending");
        // R7 poll
        wr(0, 8'h0C);
        rd(0, 8'h82, "R7 poll default order");
        wr(0, 8'h0B);
        rd(0, 8'h04, "R9 in-service read");
        chk_int(0, "R5 lower request blocked");
        wr(0, 8'h0A);
        rd(0, 8'h20, "R9 pending read");
        wr(0, 8'h62);
        wr(0, 8'h0B);
        rd(0, 8'h00, "R10 specific EOI");
        wr(0, 8'h0A);
        chk_int(1, "R5 after EOI");

        // R6 rotation: lowest = 2
        wr(0, 8'hC2);
        pulse(1); pulse(3);
        rd(0, 8'h2A, "R4 pending 1,3,5");
        wr(0, 8'h0C);
        rd(0, 8'h83, "R6 level 3 ranks first");
        wr(0, 8'h0C);
        rd(0, 8'h07, "R8 blocked poll returns 7");
        wr(0, 8'h0B);
        rd(0, 8'h08, "R8 in-service unchanged");
        wr(0, 8'h63);
        wr(0, 8'h0C);
        rd(0, 8'h85, "R6 level 5 before 1");
        pulse(4);
        wr(0, 8'h0C);
        rd(0, 8'h84, "R6 nested level 4");
        rd(0, 8'h30, "R9 in-service 4 and 5");
        wr(0, 8'h20);
        rd(0, 8'h20, "R11 nonspecific EOI clears 4");
        wr(0, 8'h20);
        rd(0, 8'h00, "R11 nonspecific EOI clears 5");
        wr(0, 8'h0C);
        rd(0, 8'h81, "R6 level 1");
        wr(0, 8'h61);

        // R12 masking
        wr(0, 8'h0A);
        wr(1, 8'h40);
        pulse(6);
        rd(0, 8'h40, "R12 masked stays pending");
        chk_int(0, "R12 masked no int");
        wr(0, 8'h0C);
        rd(0, 8'h07, "R12 masked not polled");
        wr(1, 8'h00);
        chk_int(1, "R12 unmasked raises int");
        wr(0, 8'h0C);
        rd(0, 8'h86, "R12 unmasked polled");
        wr(0, 8'h66);

        // R4 held line latches once
        @(negedge clk); irq_in[0] = 1;
        rd(0, 8'h01, "R4 held line latched");
        wr(0, 8'h0C);
        rd(0, 8'h80, "R7 poll level 0");
        rd(0, 8'h00, "R4 held line no relatch");
        wr(0, 8'h60);
        @(negedge clk); irq_in[0] = 0;

        // R2 short init: single, with mode word
        pulse(7);
        rd(0, 8'h80, "R4 pending 7");
        wr(0, 8'h13);
        chk_int(0, "R2 init clears pending");
        rd(0, 8'h00, "R2 pending cleared");
        wr(1, 8'h08); wr(1, 8'h01);
        @(negedge clk); #1;
        check(vec_base == 8'h08, "R2 short init vector", vec_base, 8'h08);
        check(casc_word == 8'h04, "R2 cascade skipped", casc_word, 8'h04);
        rd(1, 8'h00, "R2 mask kept");
        wr(1, 8'h55);
        rd(1, 8'h55, "R3 mask after short init");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule